// File: doc/BRIEF.md
# Cell Queue with Whole-Cell Counter

This block is one port's cell buffer. A producer pushes fixed-length cells into it one word at a time, and a consumer pulls them out in the same order. The block does not derive its flags from word-level full and empty. It keeps a count of whole cells, driven by two strobes. The producer raises `wr_last` on the final word of each cell. The consumer raises `rd_first` on the opening word of each cell it starts to read. From this count the block drives `cell_avail`, which tells the consumer that a complete cell is waiting. The write side drives `wr_afull` when fewer free words remain than one whole cell needs.

The buffer holds `CELLS` cells (default 9). A cell is `CELL_BYTES` bytes long on a `DATA_W`-bit bus (8 or 16 bits). Storage is an inferred two-port memory. The `ASYNC` parameter picks the clocking:

- `ASYNC = 0`: both sides run on one clock, which is wired to both clock pins. Pointer state passes from side to side directly, with no synchroniser stages.
- `ASYNC = 1`: the two sides run on independent clocks. Each pointer crosses to the other domain Gray-coded, through a two-flop synchroniser, so no event is lost.

Back-pressure rules:

- The write side is valid/ready. A word is taken on a rising `wr_clk` edge where `wr_valid` and `wr_ready` are both high. A word offered while `wr_ready` is low is dropped.
- The read side is request/response. A request is taken on a rising `rd_clk` edge where `rd_req` is high and at least one word is stored. Its data comes back one clock later, qualified by `rd_valid`.

Top module: `cell_queue`

## Requirements
- R1: An active-low `rst_n` clears the block at once, without waiting for a clock: pointers and cell count go to zero, `wr_ready`=1, `wr_afull`=0, `cell_avail`=0, `rd_valid`=0.
- R2: `wr_ready` is low exactly while `CELLS*CELL_WORDS` words are stored. A word offered while `wr_ready` is low is neither stored nor counted.
- R3: A taken write beat with `wr_last`=1 adds one to the cell count.
- R4: A taken read request with `rd_first`=1 subtracts one from the cell count.
- R5: `cell_avail` is high exactly when the cell count is at least one.
- R6: When an increment and a decrement are taken at the same edge, the cell count does not change.
- R7: `wr_afull` is high exactly when the free word space, `CELLS*CELL_WORDS` minus the stored words, is below `CELL_WORDS`.
- R8: A taken read request returns the oldest stored word on `rd_data`, with `rd_valid`=1, one `rd_clk` cycle later. A request made while no word is stored gives `rd_valid`=0 in the next cycle.
- R9: With `ASYNC`=0, `cell_avail`, `wr_ready` and `wr_afull` already reflect a write or a read right after the edge that took it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock (tie to `wr_clk` when `ASYNC`=0) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Room for one more word |
| wr_data | input | DATA_W | Write word |
| wr_last | input | 1 | Offered word ends a cell (increment strobe) |
| wr_afull | output | 1 | Less than one whole cell of free space |
| rd_req | input | 1 | Read request |
| rd_first | input | 1 | Requested word opens a cell (decrement strobe) |
| rd_valid | output | 1 | `rd_data` holds the word for last cycle's taken request |
| rd_data | output | DATA_W | Read word |
| cell_avail | output | 1 | At least one whole cell counted |

## Verification
A cell count that has drifted would show first on `cell_avail`. It would stay high after the last counted cell has been opened, or stay low after a cell's final word. In the single-clock build, either error is visible on the edge right after the strobe. A corrupted word pointer would show as a wrong or out-of-order word on `rd_data` one cycle after the affected request. It would also move `wr_afull` or `wr_ready` at the wrong fill level: for example, `wr_afull` rising at some occupancy other than the one that leaves less than one cell of room, or `wr_ready` dropping before the buffer is truly full.

// File: rtl/cq_pkg.sv
package cq_pkg;
  // Words that make up one cell on a bus of data_w bits.
  function automatic int words_per_cell(int cell_bytes, int data_w);
    return cell_bytes / (data_w / 8);
  endfunction
endpackage

// File: rtl/cq_xdom.sv
// Carries a Gray-coded pointer into the destination domain and decodes it.
module cq_xdom #(
  parameter int W     = 4,
  parameter bit ASYNC = 1'b0
) (
  input  logic         dst_clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] gray_seen;

  generate
    if (ASYNC) begin : g_two_flop
      logic [W-1:0] meta_q, stab_q;
      always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= '0;
          stab_q <= '0;
        end else begin
          meta_q <= gray_in;
          stab_q <= meta_q;
        end
      end
      assign gray_seen = stab_q;
    end else begin : g_direct
      assign gray_seen = gray_in;
    end
  endgenerate

  always_comb begin
    bin_out[W-1] = gray_seen[W-1];
    for (int i = W - 2; i >= 0; i--) bin_out[i] = bin_out[i+1] ^ gray_seen[i];
  end
endmodule

// File: rtl/cq_mem.sv
// Two-port storage: one write port, one registered read port.
module cq_mem #(
  parameter int DATA_W = 16,
  parameter int AW     = 8
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_clk,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int ENTRIES = 1 << AW;
  logic [DATA_W-1:0] store [ENTRIES];

  always_ff @(posedge wr_clk) if (we) store[waddr] <= wdata;
  always_ff @(posedge rd_clk) if (re) rdata <= store[raddr];
endmodule

// File: rtl/cq_wr_side.sv
// Write domain: word pointer, completed-cell pointer, ready and almost-full.
module cq_wr_side #(
  parameter int AW        = 8,
  parameter int CPW       = 5,
  parameter int CAP_WORDS = 243,
  parameter int CELL_WDS  = 27
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           valid,
  input  logic           last,
  input  logic [AW:0]    rptr_seen,
  output logic           ready,
  output logic           afull,
  output logic           we,
  output logic [AW-1:0]  waddr,
  output logic [AW:0]    wptr_gray,
  output logic [CPW-1:0] wcell_gray
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] CAP_P  = PW'(CAP_WORDS);
  localparam logic [PW-1:0] CELL_P = PW'(CELL_WDS);

  logic [PW-1:0]  wptr_q, occ, room;
  logic [CPW-1:0] wcell_q;

  always_comb begin
    occ   = wptr_q - rptr_seen;
    room  = CAP_P - occ;
    ready = occ < CAP_P;
    afull = room < CELL_P;
    we    = valid && ready;
    waddr = wptr_q[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q     <= '0;
      wptr_gray  <= '0;
      wcell_q    <= '0;
      wcell_gray <= '0;
    end else if (we) begin
      wptr_q    <= wptr_q + 1'b1;
      wptr_gray <= (wptr_q + 1'b1) ^ ((wptr_q + 1'b1) >> 1);
      if (last) begin
        wcell_q    <= wcell_q + 1'b1;
        wcell_gray <= (wcell_q + 1'b1) ^ ((wcell_q + 1'b1) >> 1);
      end
    end
  end
endmodule

// File: rtl/cq_rd_side.sv
// Read domain: word pointer, opened-cell pointer, response valid and cell flag.
module cq_rd_side #(
  parameter int AW  = 8,
  parameter int CPW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req,
  input  logic           first,
  input  logic [AW:0]    wptr_seen,
  input  logic [CPW-1:0] wcell_seen,
  output logic           re,
  output logic [AW-1:0]  raddr,
  output logic           rvalid,
  output logic           avail,
  output logic [AW:0]    rptr_gray
);
  logic [AW:0]    rptr_q;
  logic [CPW-1:0] rcell_q, cells;

  always_comb begin
    re    = req && (rptr_q != wptr_seen);
    raddr = rptr_q[AW-1:0];
    cells = wcell_seen - rcell_q;
    avail = cells != '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q    <= '0;
      rptr_gray <= '0;
      rcell_q   <= '0;
      rvalid    <= 1'b0;
    end else begin
      rvalid <= re;
      if (re) begin
        rptr_q    <= rptr_q + 1'b1;
        rptr_gray <= (rptr_q + 1'b1) ^ ((rptr_q + 1'b1) >> 1);
        if (first) rcell_q <= rcell_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cell_queue.sv
module cell_queue #(
  parameter int DATA_W     = 16,
  parameter int CELL_BYTES = 54,
  parameter int CELLS      = 9,
  parameter bit ASYNC      = 1'b0
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_last,
  output logic              wr_afull,
  input  logic              rd_req,
  input  logic              rd_first,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              cell_avail
);
  localparam int CELL_WDS  = cq_pkg::words_per_cell(CELL_BYTES, DATA_W);
  localparam int CAP_WORDS = CELLS * CELL_WDS;
  localparam int AW        = $clog2(CAP_WORDS);
  localparam int CPW       = $clog2(CELLS + 1) + 1;

  logic              we, re;
  logic [AW-1:0]     waddr, raddr;
  logic [AW:0]       wptr_gray, rptr_gray, wptr_rd, rptr_wr;
  logic [CPW-1:0]    wcell_gray, wcell_rd;

  cq_wr_side #(.AW(AW), .CPW(CPW), .CAP_WORDS(CAP_WORDS), .CELL_WDS(CELL_WDS)) u_wr (
    .clk(wr_clk), .rst_n(rst_n), .valid(wr_valid), .last(wr_last),
    .rptr_seen(rptr_wr), .ready(wr_ready), .afull(wr_afull), .we(we),
    .waddr(waddr), .wptr_gray(wptr_gray), .wcell_gray(wcell_gray)
  );

  cq_rd_side #(.AW(AW), .CPW(CPW)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .req(rd_req), .first(rd_first),
    .wptr_seen(wptr_rd), .wcell_seen(wcell_rd), .re(re), .raddr(raddr),
    .rvalid(rd_valid), .avail(cell_avail), .rptr_gray(rptr_gray)
  );

  cq_xdom #(.W(AW + 1), .ASYNC(ASYNC)) u_wptr_x (
    .dst_clk(rd_clk), .rst_n(rst_n), .gray_in(wptr_gray), .bin_out(wptr_rd));
  cq_xdom #(.W(CPW), .ASYNC(ASYNC)) u_wcell_x (
    .dst_clk(rd_clk), .rst_n(rst_n), .gray_in(wcell_gray), .bin_out(wcell_rd));
  cq_xdom #(.W(AW + 1), .ASYNC(ASYNC)) u_rptr_x (
    .dst_clk(wr_clk), .rst_n(rst_n), .gray_in(rptr_gray), .bin_out(rptr_wr));

  cq_mem #(.DATA_W(DATA_W), .AW(AW)) u_mem (
    .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .rd_clk(rd_clk), .re(re), .raddr(raddr), .rdata(rd_data)
  );
endmodule

// File: rtl/cell_queue_chk.sv
module cell_queue_chk #(
  parameter bit ASYNC = 1'b0
) (
  input logic wr_clk,
  input logic rd_clk,
  input logic rst_n,
  input logic wr_valid,
  input logic wr_ready,
  input logic wr_last,
  input logic wr_afull,
  input logic rd_req,
  input logic rd_first,
  input logic rd_valid,
  input logic cell_avail
);
  // R2 / R7: a full buffer always has less than a cell of room.
  p_full_implies_afull_r7: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_ready |-> wr_afull);

  // R8: no response without a request in the previous cycle.
  p_no_spurious_rvalid_r8: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  // R4 / R5: the cell flag only drops after a taken decrement.
  p_avail_fall_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $fell(cell_avail) |-> $past(rd_req && rd_first));

  generate
    if (!ASYNC) begin : g_one_clock
      // R3 / R9: the cell flag only rises after a taken increment.
      p_avail_rise_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $rose(cell_avail) |-> $past(wr_valid && wr_ready && wr_last));
      // R6: increment and decrement at one edge leave the flag as it was.
      p_same_edge_r6: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_valid && wr_ready && wr_last && rd_req && rd_first)
        |=> (!rd_valid || cell_avail == $past(cell_avail)));
    end
  endgenerate
endmodule

bind cell_queue cell_queue_chk #(.ASYNC(ASYNC)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_last(wr_last), .wr_afull(wr_afull), .rd_req(rd_req),
  .rd_first(rd_first), .rd_valid(rd_valid), .cell_avail(cell_avail)
);

// File: tb/tb_cell_queue.sv
module tb_cell_queue;
  localparam int PERIOD = 10;
  localparam int CW     = 4;    // words per cell: 4 bytes on an 8-bit bus
  localparam int NC     = 9;
  localparam int CAP    = NC * CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_last = 1'b0, rd_req = 1'b0, rd_first = 1'b0;
  logic [7:0] wr_data = '0;
  logic wr_ready, wr_afull, rd_valid, cell_avail;
  logic [7:0] rd_data;
  int checks = 0, miss = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  cell_queue #(.DATA_W(8), .CELL_BYTES(4), .CELLS(NC), .ASYNC(1'b0)) dut (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .wr_last(wr_last),
    .wr_afull(wr_afull), .rd_req(rd_req), .rd_first(rd_first),
    .rd_valid(rd_valid), .rd_data(rd_data), .cell_avail(cell_avail)
  );

  // Vector: [23]wr_valid [22]wr_last [21]rd_req [20]rd_first
  //         [19]exp avail [18]exp afull [17]exp rd_valid [15:8]wr_data [7:0]exp rd_data
  function automatic logic [23:0] mk(bit wv, bit wl, bit rq, bit rf, bit ea,
                                     bit ef, bit ev, logic [7:0] wd, logic [7:0] ed);
    return {wv, wl, rq, rf, ea, ef, ev, 1'b0, wd, ed};
  endfunction

  localparam int NV = 20;
  localparam logic [23:0] VEC [NV] = '{
    mk(1,0,0,0, 0,0,0, 8'h10, 8'h00),
    mk(1,0,0,0, 0,0,0, 8'h11, 8'h00),
    mk(1,0,0,0, 0,0,0, 8'h12, 8'h00),
    mk(1,1,0,0, 1,0,0, 8'h13, 8'h00),  // R3 increment
    mk(0,0,0,0, 1,0,0, 8'h00, 8'h00),
    mk(0,0,1,1, 0,0,1, 8'h00, 8'h10),  // R4 decrement, R8 latency
    mk(0,0,1,0, 0,0,1, 8'h00, 8'h11),
    mk(1,0,1,0, 0,0,1, 8'h20, 8'h12),
    mk(1,0,1,0, 0,0,1, 8'h21, 8'h13),
    mk(1,0,0,0, 0,0,0, 8'h22, 8'h00),
    mk(1,1,0,0, 1,0,0, 8'h23, 8'h00),
    mk(1,0,1,1, 0,0,1, 8'h30, 8'h20),
    mk(1,0,0,0, 0,0,0, 8'h31, 8'h00),
    mk(1,0,0,0, 0,0,0, 8'h32, 8'h00),
    mk(1,1,1,0, 1,0,1, 8'h33, 8'h21),
    mk(1,0,1,0, 1,0,1, 8'h40, 8'h22),
    mk(1,0,1,0, 1,0,1, 8'h41, 8'h23),
    mk(1,0,0,0, 1,0,0, 8'h42, 8'h00),
    mk(1,1,1,1, 1,0,1, 8'h43, 8'h30),  // R6 same-edge inc/dec
    mk(0,0,1,0, 1,0,1, 8'h00, 8'h31)
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    wr_valid = 0; wr_last = 0; rd_req = 0; rd_first = 0; wr_data = '0;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      miss++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, miss);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1 wr_ready", 8'(wr_ready), 8'd1);
    chk("R1 wr_afull", 8'(wr_afull), 8'd0);
    chk("R1 cell_avail", 8'(cell_avail), 8'd0);
    chk("R1 rd_valid", 8'(rd_valid), 8'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table: R3 R4 R5 R6 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      v = VEC[i];
      wr_valid = v[23]; wr_last = v[22]; rd_req = v[21]; rd_first = v[20];
      wr_data = v[15:8];
      tick();
      chk($sformatf("R5 avail vec%0d", i), 8'(cell_avail), 8'(v[19]));
      chk($sformatf("R7 afull vec%0d", i), 8'(wr_afull), 8'(v[18]));
      chk($sformatf("R8 rd_valid vec%0d", i), 8'(rd_valid), 8'(v[17]));
      if (v[17]) chk($sformatf("R8 rd_data vec%0d", i), rd_data, v[7:0]);
    end
    idle_inputs();

    // R1: asynchronous clear while a cell is counted
    #(PERIOD/4) rst_n = 1'b0;
    #1;
    chk("R1 async avail clear", 8'(cell_avail), 8'd0);
    tick();
    chk("R1 ready after clear", 8'(wr_ready), 8'd1);
    rst_n = 1'b1;
    tick();

    // Fill to capacity: R7 boundary, R2 full
    for (int i = 0; i < CAP; i++) begin
      wr_valid = 1; wr_data = 8'hA0 + 8'(i); wr_last = (i % CW) == CW - 1;
      tick();
      if (i == CAP - CW - 1) chk("R7 afull at one cell free", 8'(wr_afull), 8'd0);
      if (i == CAP - CW)     chk("R7 afull below one cell", 8'(wr_afull), 8'd1);
    end
    chk("R2 ready low when full", 8'(wr_ready), 8'd0);
    chk("R5 avail at nine cells", 8'(cell_avail), 8'd1);
    // R2: offered words while full are dropped
    wr_valid = 1; wr_last = 1; wr_data = 8'hEE;
    tick(); tick();
    chk("R2 ready stays low", 8'(wr_ready), 8'd0);
    idle_inputs();

    // Drain: R8 order, R4 count, R2 ready back
    for (int i = 0; i < CAP; i++) begin
      rd_req = 1; rd_first = (i % CW) == 0;
      tick();
      chk($sformatf("R8 drain data %0d", i), rd_data, 8'hA0 + 8'(i));
      if (i % CW == 0)
        chk($sformatf("R4 avail after cell %0d opened", i / CW),
            8'(cell_avail), 8'((i / CW) < NC - 1));
      if (i == 0) chk("R2 ready after one read", 8'(wr_ready), 8'd1);
    end
    rd_req = 1; rd_first = 1;
    tick();
    chk("R8 empty request no valid", 8'(rd_valid), 8'd0);
    chk("R2 dropped words not counted", 8'(cell_avail), 8'd0);
    idle_inputs();
    tick();

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, miss);
    $finish;
  end
endmodule